// File: doc/BRIEF.md
# Prefix-Aware Register Operand Decoder

This block sits just behind an instruction byte fetcher. It accepts one byte per cycle in which `in_valid` is high. It watches for the two index-prefix byte values. It splits the next opcode byte into a destination field (bits 5:3) and a source field (bits 2:0), and turns each 3-bit field into a 4-bit register-file select. When a prefix is pending, the pointer-pair halves are redirected to the matching index-register halves.

A 2-bit operand-count hint is taken together with the opcode byte. The block then collects zero, one or two operand bytes. It presents the instruction in one registered bundle: both selects, memory-operand flags, the applied prefix, an 8-bit immediate, and a 16-bit word. The word is zero, a sign-extended byte, or an address assembled from two bytes. A one-cycle `o_done` pulse marks each new bundle.

The controller has three states. `S_OPC` waits for an opcode or a prefix. `S_LO` waits for the first operand byte. `S_HI` waits for the high address byte.

The transitions are:
- A prefix byte in `S_OPC` stays in `S_OPC` and records the prefix.
- An opcode with hint 0 stays in `S_OPC` and completes the instruction.
- An opcode with a non-zero hint goes to `S_LO`.
- `S_LO` returns to `S_OPC` and completes when the hint was 1. Otherwise it goes to `S_HI`.
- `S_HI` returns to `S_OPC` and completes.

No state changes while `in_valid` is low.

Top module: `opnd_decoder`

## Requirements
- R1: While reset is asserted, and until the first completion, `o_done` is 0, both selects are 0, both memory flags are 0, `o_pfx` is 0, and `o_word` and `o_imm` are 0.
- R2: Without a pending prefix, field codes 000–101 and 111 produce a select equal to the code (B=0, C=1, D=2, E=3, H=4, L=5, A=7), with the memory flag at 0.
- R3: After prefix byte 0xDD, code 100 gives select 8 (IX high) and code 101 gives select 9 (IX low). The other register codes are unchanged, and `o_pfx` reads 1.
- R4: After prefix byte 0xFD, code 100 gives select 10 (IY high) and code 101 gives select 11 (IY low). The other register codes are unchanged, and `o_pfx` reads 2.
- R5: Code 110 sets the field's memory flag and gives select 6, with or without a prefix.
- R6: A prefix applies only to the next opcode byte. It is cleared when that opcode is taken, and it is cleared by reset.
- R7: When several prefix bytes arrive in a row, only the last one applies.
- R8: Hint 1 takes one operand byte. `o_imm` equals that byte, and `o_word` is the byte sign-extended to 16 bits.
- R9: Hint 2 or 3 takes two operand bytes, low first. `o_word` is {high, low} and `o_imm` is the low byte. Hint 0 gives `o_word` = `o_imm` = 0.
- R10: `o_done` is high in the cycle after the last byte of an instruction is taken, and only then. The hint is read only with the opcode byte.
- R11: Cycles with `in_valid` low change no state and no output. Operand bytes equal to 0xDD or 0xFD are treated as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Instruction byte |
| in_len | input | 2 | Operand-count hint, read with the opcode |
| o_done | output | 1 | One-cycle pulse: new bundle valid |
| o_dst_sel | output | 4 | Destination register select |
| o_src_sel | output | 4 | Source register select |
| o_dst_mem | output | 1 | Destination is the memory operand |
| o_src_mem | output | 1 | Source is the memory operand |
| o_pfx | output | 2 | Applied prefix: 0 none, 1 IX, 2 IY |
| o_imm | output | 8 | Immediate byte |
| o_word | output | 16 | Sign-extended byte, or assembled address |

## Verification
The hardest case to reach from the ports is a prefix that must survive idle cycles, and then disappear after exactly one opcode. The stimulus sweeps every opcode under each prefix value, with the prefixes interleaved. As a result, an unprefixed opcode always follows a prefixed one, and idle cycles are inserted between some prefixes and their opcodes. Operand bytes that happen to equal a prefix value are also generated. The hint is deliberately corrupted on those operand bytes, to show that it is read only with the opcode.

// File: rtl/opd_pkg.sv
package opd_pkg;
    typedef enum logic [1:0] {PX_NONE = 2'd0, PX_IX = 2'd1, PX_IY = 2'd2} pfx_e;
    typedef enum logic [1:0] {S_OPC = 2'd0, S_LO = 2'd1, S_HI = 2'd2} st_e;
    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_MEM = 4'd6;
    localparam logic [SEL_W-1:0] SEL_IXH = 4'd8;
    localparam logic [SEL_W-1:0] SEL_IXL = 4'd9;
    localparam logic [SEL_W-1:0] SEL_IYH = 4'd10;
    localparam logic [SEL_W-1:0] SEL_IYL = 4'd11;
endpackage

// File: rtl/opd_regmap.sv
module opd_regmap
    import opd_pkg::*;
(
    input  logic [2:0]       code,
    input  pfx_e             pfx,
    output logic [SEL_W-1:0] sel,
    output logic             mem
);
    always_comb begin
        mem = 1'b0;
        sel = {1'b0, code};
        unique case (code)
            3'd6: begin
                mem = 1'b1;
                sel = SEL_MEM;
            end
            3'd4: begin
                if (pfx == PX_IX)      sel = SEL_IXH;
                else if (pfx == PX_IY) sel = SEL_IYH;
            end
            3'd5: begin
                if (pfx == PX_IX)      sel = SEL_IXL;
                else if (pfx == PX_IY) sel = SEL_IYL;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opd_operand_asm.sv
module opd_operand_asm #(
    parameter int BYTE_W = 8
) (
    input  logic [1:0]          len,
    input  logic [BYTE_W-1:0]   lo,
    input  logic [BYTE_W-1:0]   hi,
    output logic [2*BYTE_W-1:0] word,
    output logic [BYTE_W-1:0]   imm
);
    always_comb begin
        unique case (len)
            2'd0: begin
                word = '0;
                imm  = '0;
            end
            2'd1: begin
                word = {{BYTE_W{lo[BYTE_W-1]}}, lo};
                imm  = lo;
            end
            default: begin
                word = {hi, lo};
                imm  = lo;
            end
        endcase
    end
endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
    import opd_pkg::*;
#(
    parameter int          BYTE_W  = 8,
    parameter logic [7:0]  PFX_IXB = 8'hDD,
    parameter logic [7:0]  PFX_IYB = 8'hFD
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [BYTE_W-1:0]     in_byte,
    input  logic [1:0]            in_len,
    output logic                  o_done,
    output logic [SEL_W-1:0]      o_dst_sel,
    output logic [SEL_W-1:0]      o_src_sel,
    output logic                  o_dst_mem,
    output logic                  o_src_mem,
    output logic [1:0]            o_pfx,
    output logic [BYTE_W-1:0]     o_imm,
    output logic [2*BYTE_W-1:0]   o_word
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NFLD   = 2;

    st_e  st, st_nx;
    pfx_e pfx_q;
    logic [1:0]        len_q;
    logic [BYTE_W-1:0] lo_q;

    logic [SEL_W-1:0] map_sel [NFLD];
    logic             map_mem [NFLD];
    logic [SEL_W-1:0] pend_sel [NFLD];
    logic             pend_mem [NFLD];
    pfx_e             pend_pfx;

    logic is_pfx, finish;
    logic [1:0]        len_eff;
    logic [BYTE_W-1:0] asm_lo;
    logic [WORD_W-1:0] asm_word;
    logic [BYTE_W-1:0] asm_imm;

    // field 0 = destination bits 5:3, field 1 = source bits 2:0
    for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
        opd_regmap u_map (
            .code (in_byte[5-3*gi -: 3]),
            .pfx  (pfx_q),
            .sel  (map_sel[gi]),
            .mem  (map_mem[gi])
        );
    end

    assign is_pfx  = (st == S_OPC) && ((in_byte == PFX_IXB) || (in_byte == PFX_IYB));
    assign len_eff = (st == S_OPC) ? in_len : len_q;
    assign asm_lo  = (st == S_LO) ? in_byte : lo_q;
    assign finish  = in_valid && (((st == S_OPC) && !is_pfx && (in_len == 2'd0)) ||
                                  ((st == S_LO) && (len_q == 2'd1)) ||
                                  (st == S_HI));

    opd_operand_asm #(.BYTE_W(BYTE_W)) u_asm (
        .len  (len_eff),
        .lo   (asm_lo),
        .hi   (in_byte),
        .word (asm_word),
        .imm  (asm_imm)
    );

    always_comb begin
        st_nx = st;
        if (in_valid) begin
            unique case (st)
                S_OPC: if (!is_pfx && (in_len != 2'd0)) st_nx = S_LO;
                S_LO:  st_nx = (len_q == 2'd1) ? S_OPC : S_HI;
                S_HI:  st_nx = S_OPC;
                default: st_nx = S_OPC;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_OPC;
        else        st <= st_nx;
    end

    // working registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx_q     <= PX_NONE;
            len_q     <= 2'd0;
            lo_q      <= '0;
            pend_pfx  <= PX_NONE;
            for (int i = 0; i < NFLD; i++) begin
                pend_sel[i] <= '0;
                pend_mem[i] <= 1'b0;
            end
            o_done    <= 1'b0;
            o_dst_sel <= '0;
            o_src_sel <= '0;
            o_dst_mem <= 1'b0;
            o_src_mem <= 1'b0;
            o_pfx     <= 2'd0;
            o_imm     <= '0;
            o_word    <= '0;
        end else begin
            o_done <= finish;
            if (in_valid && (st == S_OPC)) begin
                if (is_pfx) begin
                    pfx_q <= (in_byte == PFX_IXB) ? PX_IX : PX_IY;
                end else begin
                    pfx_q    <= PX_NONE;
                    len_q    <= in_len;
                    pend_pfx <= pfx_q;
                    for (int i = 0; i < NFLD; i++) begin
                        pend_sel[i] <= map_sel[i];
                        pend_mem[i] <= map_mem[i];
                    end
                end
            end
            if (in_valid && (st == S_LO)) lo_q <= in_byte;
            if (finish) begin
                if (st == S_OPC) begin
                    o_dst_sel <= map_sel[0];
                    o_src_sel <= map_sel[1];
                    o_dst_mem <= map_mem[0];
                    o_src_mem <= map_mem[1];
                    o_pfx     <= pfx_q;
                end else begin
                    o_dst_sel <= pend_sel[0];
                    o_src_sel <= pend_sel[1];
                    o_dst_mem <= pend_mem[0];
                    o_src_mem <= pend_mem[1];
                    o_pfx     <= pend_pfx;
                end
                o_word <= asm_word;
                o_imm  <= asm_imm;
            end
        end
    end
endmodule

// File: rtl/opd_chk.sv
module opd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       o_done,
    input logic [3:0] o_dst_sel,
    input logic [3:0] o_src_sel,
    input logic       o_dst_mem,
    input logic       o_src_mem,
    input logic [1:0] o_pfx
);
    // R2
    plain_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_pfx == 2'd0) |-> (o_src_sel < 4'd8 && o_dst_sel < 4'd8));
    // R3
    ix_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_pfx == 2'd1) |-> (o_src_sel < 4'd10 && o_dst_sel < 4'd10));
    // R4
    iy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_done && o_pfx == 2'd2) |-> (o_src_sel != 4'd8 && o_src_sel != 4'd9 &&
                                       o_dst_sel != 4'd8 && o_dst_sel != 4'd9));
    // R5
    mem_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |-> ((o_src_mem == (o_src_sel == 4'd6)) && (o_dst_mem == (o_dst_sel == 4'd6))));
    // R11
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !o_done);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(o_src_sel) && $stable(o_dst_sel) && $stable(o_pfx)));
    // R12 style pfx code range, tied to R3/R4
    // R3
    pfx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_pfx != 2'd3);
endmodule

bind opnd_decoder opd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .o_done    (o_done),
    .o_dst_sel (o_dst_sel),
    .o_src_sel (o_src_sel),
    .o_dst_mem (o_dst_mem),
    .o_src_mem (o_src_mem),
    .o_pfx     (o_pfx)
);

// File: tb/sim_opnd_decoder.sv
`timescale 1ns/1ps
module sim_opnd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [1:0]  in_len = 2'd0;
    logic        o_done;
    logic [3:0]  o_dst_sel, o_src_sel;
    logic        o_dst_mem, o_src_mem;
    logic [1:0]  o_pfx;
    logic [7:0]  o_imm;
    logic [15:0] o_word;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    opnd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_len(in_len),
        .o_done(o_done), .o_dst_sel(o_dst_sel), .o_src_sel(o_src_sel),
        .o_dst_mem(o_dst_mem), .o_src_mem(o_src_mem), .o_pfx(o_pfx),
        .o_imm(o_imm), .o_word(o_word)
    );

    task automatic cmp(input int got, input int exp, input string req);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // caller is at a falling edge; byte is taken at the next rising edge
    task automatic put(input logic [7:0] b, input logic [1:0] l);
        in_valid = 1'b1;
        in_byte  = b;
        in_len   = l;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_byte  = 8'hDD;
        in_len   = 2'd1;
        @(negedge clk);
    endtask

    function automatic int exp_sel(input int code, input int p);
        if (code == 4 && p == 1) return 8;
        if (code == 5 && p == 1) return 9;
        if (code == 4 && p == 2) return 10;
        if (code == 5 && p == 2) return 11;
        return code;
    endfunction

    task automatic check_bundle(input int op, input int p, input int len,
                                input int lo, input int hi, input string req);
        int ew, ei;
        if (len == 0) begin ew = 0; ei = 0; end
        else if (len == 1) begin ew = (lo >= 128) ? (lo + 16'hFF00) : lo; ei = lo; end
        else begin ew = hi * 256 + lo; ei = lo; end
        cmp(o_done, 1, {req, " R10 done"});
        cmp(o_dst_sel, exp_sel((op >> 3) & 7, p), {req, " dst"});
        cmp(o_src_sel, exp_sel(op & 7, p), {req, " src"});
        cmp(o_dst_mem, (((op >> 3) & 7) == 6) ? 1 : 0, {req, " R5 dst mem"});
        cmp(o_src_mem, ((op & 7) == 6) ? 1 : 0, {req, " R5 src mem"});
        cmp(o_pfx, p, {req, " pfx"});
        cmp(o_word, ew, {req, " R8/R9 word"});
        cmp(o_imm, ei, {req, " R8/R9 imm"});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp(o_done, 0, "R1 done");
        cmp(o_dst_sel, 0, "R1 dst");
        cmp(o_src_sel, 0, "R1 src");
        cmp(o_pfx, 0, "R1 pfx");
        cmp(o_word, 0, "R1 word");
        cmp(o_imm, 0, "R1 imm");
        // R6: prefix taken during reset must not stick
        in_valid = 1'b1; in_byte = 8'hFD; @(negedge clk); in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        put(8'h65, 2'd0);
        check_bundle(8'h65, 0, 0, 0, 0, "R6 reset clears");

        // sweep: every opcode under each prefix, interleaved
        for (int op = 0; op < 256; op++) begin
            if (op == 8'hDD || op == 8'hFD) continue;
            for (int p = 0; p < 3; p++) begin
                int len = (op + p) % 3;
                int lo  = (op + 1) & 8'hFF;
                int hi  = (op + 8'h22) & 8'hFF;
                string rq = (p == 0) ? "R2/R6" : ((p == 1) ? "R3" : "R4");
                if (p == 1) put(8'hDD, 2'd3);
                if (p == 2) put(8'hFD, 2'd3);
                if (p != 0 && op % 7 == 0) begin
                    idle();
                    cmp(o_done, 0, "R11 idle after prefix");
                    idle();
                end
                put(8'(op), 2'(len));
                if (len >= 1) put(8'(lo), 2'(~len));
                if (len == 2) put(8'(hi), 2'd0);
                check_bundle(op, p, len, lo, hi, rq);
                idle();
                cmp(o_done, 0, "R10 pulse width");
                cmp(o_word, (len == 0) ? 0 : ((len == 1) ? ((lo >= 128) ? lo + 16'hFF00 : lo) : hi * 256 + lo),
                    "R11 hold");
            end
        end

        // R7: consecutive prefixes, last wins
        put(8'hDD, 2'd0); put(8'hFD, 2'd0); put(8'h64, 2'd0);
        check_bundle(8'h64, 2, 0, 0, 0, "R7 DD-FD");
        put(8'hFD, 2'd0); put(8'hFD, 2'd0); put(8'hDD, 2'd0); put(8'h6C, 2'd2);
        put(8'hFD, 2'd1); put(8'hDD, 2'd1);
        check_bundle(8'h6C, 1, 2, 8'hFD, 8'hDD, "R7 R11 FD-FD-DD data prefixes");
        // hint 3 treated as two bytes (R9)
        put(8'h45, 2'd3); put(8'h80, 2'd0); put(8'h7F, 2'd0);
        check_bundle(8'h45, 0, 2, 8'h80, 8'h7F, "R9 hint3");
        // one-byte negative boundary (R8)
        put(8'h2E, 2'd1); put(8'h80, 2'd0);
        check_bundle(8'h2E, 0, 1, 8'h80, 0, "R8 -128");
        put(8'h2E, 2'd1); put(8'h7F, 2'd2);
        check_bundle(8'h2E, 0, 1, 8'h7F, 0, "R8 +127");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule